// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired sequencer for a 32-bit multicycle datapath. It holds a 4-bit step register and steps through a fixed path of states for each instruction class. In every state it drives the datapath write strobes and mux selects as one fixed pattern. The step after decode is chosen from a 6-bit opcode. The register file, ALU and memory sit outside the block.

Every instruction starts with a fetch step and a decode step. It then takes its own path. A load uses five cycles, a store four, a register operation four, an immediate OR four, a branch three and a jump three. Outputs that a state does not use are driven to 0, so the outputs are fully determined in every cycle. The current state number is brought out on a port, so the datapath can be checked and debugged against it.

Top module: `mcc_ctrl`

## Requirements
- R1: A synchronous active-low reset sets `state_o` to 0 on the next rising edge. This holds even in the middle of an instruction. `state_o` always carries the state number, 0 to 11.
- R2: State 0 (fetch) drives `pc_wr_o`=1, `ir_wr_o`=1, `alu_op_o`=0 (add), `alu_a_reg_o`=0, `alu_b_sel_o`=0 and `addr_from_alu_o`=0. The state after it is always 1.
- R3: State 1 (decode) drives `tgt_wr_o`=1, `ext_sign_o`=1, `alu_op_o`=0 and `alu_b_sel_o`=2. The state after it depends on the opcode. Opcode 0x23 or 0x2B goes to 2. Opcode 0x00 goes to 6. Opcode 0x04 goes to 8. Opcode 0x0D goes to 10. Opcode 0x02 goes to 9.
- R4: The load (opcode 0x23) follows 2→3→4→0 and takes 5 cycles counted from fetch. States 2, 3 and 4 drive `ext_sign_o`=1, `alu_a_reg_o`=1, `alu_b_sel_o`=3 and `alu_op_o`=0. State 3 also drives `addr_from_alu_o`=1. State 4 also drives `reg_wr_o`=1 and `wb_mem_o`=1.
- R5: The store (opcode 0x2B) follows 2→5→0. State 5 drives the state 2 pattern and also `mem_wr_o`=1.
- R6: The register operation follows 6→7→0. Both states drive `dst_rd_o`=1, `alu_a_reg_o`=1, `alu_b_sel_o`=1 and `alu_op_o`=2 (function field). State 7 also drives `reg_wr_o`=1 with `wb_mem_o`=0.
- R7: State 8 (branch) drives `pc_wr_cond_o`=1, `alu_op_o`=1 (subtract), `alu_a_reg_o`=1, `alu_b_sel_o`=1 and `pc_src_o`=1 (stored target). The state after it is 0.
- R8: The immediate OR follows 10→11→0. Both states drive `alu_a_reg_o`=1, `alu_b_sel_o`=3, `alu_op_o`=3 (or) and `ext_sign_o`=0. State 11 also drives `reg_wr_o`=1.
- R9: The jump follows 0→1→9→0, which is three cycles. State 9 drives `pc_wr_o`=1 with `pc_src_o`=2 (jump target).
- R10: Any other opcode seen in state 1 sends the sequencer back to state 0. Such an instruction takes two cycles.
- R11: In every state, each output not named for that state in R2 to R9 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the instruction register |
| state_o | output | 4 | Current state number |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write when ALU result is zero |
| ir_wr_o | output | 1 | Instruction register load |
| mem_wr_o | output | 1 | Memory write |
| reg_wr_o | output | 1 | Register file write |
| tgt_wr_o | output | 1 | Branch target register load |
| addr_from_alu_o | output | 1 | Memory address from ALU result (0: PC) |
| dst_rd_o | output | 1 | Destination is rd field (0: rt) |
| wb_mem_o | output | 1 | Write-back data from memory (0: ALU) |
| ext_sign_o | output | 1 | Sign-extend immediate (0: zero-extend) |
| pc_src_o | output | 2 | PC source: 0 ALU, 1 stored target, 2 jump target |
| alu_a_reg_o | output | 1 | ALU A from register (0: PC) |
| alu_b_sel_o | output | 2 | ALU B: 0 constant 4, 1 register, 2 shifted immediate, 3 immediate |
| alu_op_o | output | 2 | ALU operation: 0 add, 1 sub, 2 function field, 3 or |

## Verification
The bench sweeps all 64 opcode values, holding each one for a whole instruction. It follows each instruction from fetch until it returns to state 0. In every cycle it compares the state and the full 17-bit output vector against an expected value. The six valid opcodes each show a distinct path and cycle count. The 58 invalid opcodes show the early return from decode. A reset applied in the middle of a register operation shows that reset overrides the path.

// File: rtl/mcc_pkg.sv
// Package: shared widths, state numbering, opcodes and the control word.
// Assumes: opcodes follow the 6-bit field encoding listed in the brief.
package mcc_pkg;
    localparam int STATE_W = 4;
    localparam int OP_W    = 6;
    localparam int SEL_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_ADDR    = 4'd2,
        ST_LD_MEM  = 4'd3,
        ST_LD_WB   = 4'd4,
        ST_ST_MEM  = 4'd5,
        ST_R_EXEC  = 4'd6,
        ST_R_DONE  = 4'd7,
        ST_BRANCH  = 4'd8,
        ST_JUMP    = 4'd9,
        ST_OR_EXEC = 4'd10,
        ST_OR_DONE = 4'd11
    } state_e;

    localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'h0D;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

    localparam logic [SEL_W-1:0] ALU_ADD  = 2'd0;
    localparam logic [SEL_W-1:0] ALU_SUB  = 2'd1;
    localparam logic [SEL_W-1:0] ALU_FUNC = 2'd2;
    localparam logic [SEL_W-1:0] ALU_OR   = 2'd3;

    localparam logic [SEL_W-1:0] B_FOUR   = 2'd0;
    localparam logic [SEL_W-1:0] B_REG    = 2'd1;
    localparam logic [SEL_W-1:0] B_SHIMM  = 2'd2;
    localparam logic [SEL_W-1:0] B_IMM    = 2'd3;

    localparam logic [SEL_W-1:0] PCS_ALU  = 2'd0;
    localparam logic [SEL_W-1:0] PCS_TGT  = 2'd1;
    localparam logic [SEL_W-1:0] PCS_JMP  = 2'd2;

    typedef struct packed {
        logic             pc_wr;
        logic             pc_wr_cond;
        logic             ir_wr;
        logic             mem_wr;
        logic             reg_wr;
        logic             tgt_wr;
        logic             addr_from_alu;
        logic             dst_rd;
        logic             wb_mem;
        logic             ext_sign;
        logic [SEL_W-1:0] pc_src;
        logic             alu_a_reg;
        logic [SEL_W-1:0] alu_b_sel;
        logic [SEL_W-1:0] alu_op;
    } ctrl_t;
endpackage

// File: rtl/mcc_next_state.sv
// Module: next-state function of the sequencer.
// Assumes: the opcode is stable while the decode and address states are active.
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_e              cur_i,
    input  logic [OP_W-1:0]     opcode_i,
    output state_e              nxt_o
);
    // Pick the successor state from the current state and the opcode.
    always_comb begin
        nxt_o = ST_FETCH;
        case (cur_i)
            ST_FETCH:   nxt_o = ST_DECODE;
            ST_DECODE: begin
                case (opcode_i)
                    OPC_LOAD, OPC_STORE: nxt_o = ST_ADDR;
                    OPC_REG:             nxt_o = ST_R_EXEC;
                    OPC_BEQ:             nxt_o = ST_BRANCH;
                    OPC_ORI:             nxt_o = ST_OR_EXEC;
                    OPC_JUMP:            nxt_o = ST_JUMP;
                    default:             nxt_o = ST_FETCH;
                endcase
            end
            ST_ADDR:    nxt_o = (opcode_i == OPC_STORE) ? ST_ST_MEM : ST_LD_MEM;
            ST_LD_MEM:  nxt_o = ST_LD_WB;
            ST_R_EXEC:  nxt_o = ST_R_DONE;
            ST_OR_EXEC: nxt_o = ST_OR_DONE;
            default:    nxt_o = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_ctrl_decode.sv
// Module: maps each state to its fixed control word.
// Assumes: outputs not used by a state are driven 0 so that they are deterministic.
module mcc_ctrl_decode
    import mcc_pkg::*;
(
    input  state_e cur_i,
    output ctrl_t  ctrl_o
);
    // Build the control word for the current state on top of an all-zero default.
    always_comb begin
        ctrl_o = '0;
        case (cur_i)
            ST_FETCH: begin
                ctrl_o.pc_wr  = 1'b1;
                ctrl_o.ir_wr  = 1'b1;
                ctrl_o.alu_op = ALU_ADD;
            end
            ST_DECODE: begin
                ctrl_o.tgt_wr    = 1'b1;
                ctrl_o.ext_sign  = 1'b1;
                ctrl_o.alu_b_sel = B_SHIMM;
            end
            ST_ADDR, ST_LD_MEM, ST_LD_WB, ST_ST_MEM: begin
                ctrl_o.ext_sign      = 1'b1;
                ctrl_o.alu_a_reg     = 1'b1;
                ctrl_o.alu_b_sel     = B_IMM;
                ctrl_o.addr_from_alu = (cur_i == ST_LD_MEM);
                ctrl_o.reg_wr        = (cur_i == ST_LD_WB);
                ctrl_o.wb_mem        = (cur_i == ST_LD_WB);
                ctrl_o.mem_wr        = (cur_i == ST_ST_MEM);
            end
            ST_R_EXEC, ST_R_DONE: begin
                ctrl_o.dst_rd    = 1'b1;
                ctrl_o.alu_a_reg = 1'b1;
                ctrl_o.alu_b_sel = B_REG;
                ctrl_o.alu_op    = ALU_FUNC;
                ctrl_o.reg_wr    = (cur_i == ST_R_DONE);
            end
            ST_BRANCH: begin
                ctrl_o.pc_wr_cond = 1'b1;
                ctrl_o.alu_op     = ALU_SUB;
                ctrl_o.alu_a_reg  = 1'b1;
                ctrl_o.alu_b_sel  = B_REG;
                ctrl_o.pc_src     = PCS_TGT;
            end
            ST_JUMP: begin
                ctrl_o.pc_wr  = 1'b1;
                ctrl_o.pc_src = PCS_JMP;
            end
            ST_OR_EXEC, ST_OR_DONE: begin
                ctrl_o.alu_a_reg = 1'b1;
                ctrl_o.alu_b_sel = B_IMM;
                ctrl_o.alu_op    = ALU_OR;
                ctrl_o.reg_wr    = (cur_i == ST_OR_DONE);
            end
            default: ctrl_o = '0;
        endcase
    end
endmodule

// File: rtl/mcc_ctrl.sv
// Module: top of the multicycle sequencer; state register plus the two decoders.
// Assumes: rst_n is synchronous and active low; opcode comes from the instruction register.
module mcc_ctrl
    import mcc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    opcode_i,
    output logic [STATE_W-1:0] state_o,
    output logic               pc_wr_o,
    output logic               pc_wr_cond_o,
    output logic               ir_wr_o,
    output logic               mem_wr_o,
    output logic               reg_wr_o,
    output logic               tgt_wr_o,
    output logic               addr_from_alu_o,
    output logic               dst_rd_o,
    output logic               wb_mem_o,
    output logic               ext_sign_o,
    output logic [SEL_W-1:0]   pc_src_o,
    output logic               alu_a_reg_o,
    output logic [SEL_W-1:0]   alu_b_sel_o,
    output logic [SEL_W-1:0]   alu_op_o
);
    state_e cur_q;
    state_e nxt;
    ctrl_t  ctrl;

    mcc_next_state u_next (
        .cur_i    (cur_q),
        .opcode_i (opcode_i),
        .nxt_o    (nxt)
    );

    mcc_ctrl_decode u_decode (
        .cur_i  (cur_q),
        .ctrl_o (ctrl)
    );

    // State register with synchronous active-low reset to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= ST_FETCH;
        else        cur_q <= nxt;
    end

    // Unpack the control word onto the ports.
    always_comb begin
        state_o         = cur_q;
        pc_wr_o         = ctrl.pc_wr;
        pc_wr_cond_o    = ctrl.pc_wr_cond;
        ir_wr_o         = ctrl.ir_wr;
        mem_wr_o        = ctrl.mem_wr;
        reg_wr_o        = ctrl.reg_wr;
        tgt_wr_o        = ctrl.tgt_wr;
        addr_from_alu_o = ctrl.addr_from_alu;
        dst_rd_o        = ctrl.dst_rd;
        wb_mem_o        = ctrl.wb_mem;
        ext_sign_o      = ctrl.ext_sign;
        pc_src_o        = ctrl.pc_src;
        alu_a_reg_o     = ctrl.alu_a_reg;
        alu_b_sel_o     = ctrl.alu_b_sel;
        alu_op_o        = ctrl.alu_op;
    end
endmodule

// File: rtl/mcc_ctrl_checker.sv
// Module: temporal checks on the sequencer ports, bound into mcc_ctrl.
// Assumes: the same reset and clock as the bound instance.
module mcc_ctrl_checker
    import mcc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [OP_W-1:0]    opcode_i,
    input logic [STATE_W-1:0] state_o,
    input logic               pc_wr_o,
    input logic               pc_wr_cond_o,
    input logic               mem_wr_o,
    input logic               reg_wr_o,
    input logic [SEL_W-1:0]   pc_src_o
);
    assert_reset_to_fetch_R1: assert property (@(posedge clk)
        !rst_n |=> state_o == 4'd0);

    assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 4'd0 |=> state_o == 4'd1);

    assert_store_after_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd2 && opcode_i == OPC_STORE) |=> mem_wr_o);

    assert_load_wb_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 4'd3 |=> (state_o == 4'd4 && reg_wr_o));

    assert_terminal_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd4 || state_o == 4'd5 || state_o == 4'd7 ||
         state_o == 4'd8 || state_o == 4'd9 || state_o == 4'd11) |=> state_o == 4'd0);

    assert_bad_opcode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd1 && opcode_i != OPC_REG && opcode_i != OPC_JUMP &&
         opcode_i != OPC_BEQ && opcode_i != OPC_ORI && opcode_i != OPC_LOAD &&
         opcode_i != OPC_STORE) |=> state_o == 4'd0);

    // R11: at most one architectural write strobe at a time
    assert_single_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_wr_o, pc_wr_cond_o, mem_wr_o, reg_wr_o}));

    assert_jump_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_o && pc_src_o == PCS_JMP) |-> state_o == 4'd9);
endmodule

bind mcc_ctrl mcc_ctrl_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .opcode_i     (opcode_i),
    .state_o      (state_o),
    .pc_wr_o      (pc_wr_o),
    .pc_wr_cond_o (pc_wr_cond_o),
    .mem_wr_o     (mem_wr_o),
    .reg_wr_o     (reg_wr_o),
    .pc_src_o     (pc_src_o)
);

// File: tb/mcc_ctrl_bench.sv
`timescale 1ns/100ps
// Bench: sweeps every opcode through a full instruction and checks state and outputs each cycle.
module mcc_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic [3:0] state;
    logic       pc_wr, pc_wr_cond, ir_wr, mem_wr, reg_wr, tgt_wr;
    logic       addr_alu, dst_rd, wb_mem, ext_sign, alu_a;
    logic [1:0] pc_src, alu_b, alu_op;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;

    always #2.5 clk = ~clk;

    mcc_ctrl u_mcc_ctrl (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .state_o(state),
        .pc_wr_o(pc_wr), .pc_wr_cond_o(pc_wr_cond), .ir_wr_o(ir_wr),
        .mem_wr_o(mem_wr), .reg_wr_o(reg_wr), .tgt_wr_o(tgt_wr),
        .addr_from_alu_o(addr_alu), .dst_rd_o(dst_rd), .wb_mem_o(wb_mem),
        .ext_sign_o(ext_sign), .pc_src_o(pc_src), .alu_a_reg_o(alu_a),
        .alu_b_sel_o(alu_b), .alu_op_o(alu_op)
    );

    // Expected next state from the requirements R2..R10.
    function automatic logic [3:0] ref_next(input logic [3:0] s, input logic [5:0] op);
        case (s)
            4'd0: return 4'd1;
            4'd1: case (op)
                      6'h23, 6'h2B: return 4'd2;
                      6'h00: return 4'd6;
                      6'h04: return 4'd8;
                      6'h0D: return 4'd10;
                      6'h02: return 4'd9;
                      default: return 4'd0;
                  endcase
            4'd2: return (op == 6'h2B) ? 4'd5 : 4'd3;
            4'd3: return 4'd4;
            4'd6: return 4'd7;
            4'd10: return 4'd11;
            default: return 4'd0;
        endcase
    endfunction

    // Expected 17-bit vector: pcw,pcc,irw,mw,rw,tw,adr,dst,wb,ext,pcs[2],a,b[2],op[2].
    function automatic logic [16:0] ref_vec(input logic [3:0] s);
        logic pcw = 0, pcc = 0, irw = 0, mw = 0, rw = 0, tw = 0;
        logic adr = 0, dst = 0, wb = 0, ext = 0, a = 0;
        logic [1:0] pcs = 0, b = 0, op = 0;
        case (s)
            4'd0: begin pcw = 1; irw = 1; end
            4'd1: begin tw = 1; ext = 1; b = 2; end
            4'd2, 4'd3, 4'd4, 4'd5: begin
                ext = 1; a = 1; b = 3;
                adr = (s == 4'd3); rw = (s == 4'd4); wb = (s == 4'd4); mw = (s == 4'd5);
            end
            4'd6, 4'd7: begin dst = 1; a = 1; b = 1; op = 2; rw = (s == 4'd7); end
            4'd8: begin pcc = 1; op = 1; a = 1; b = 1; pcs = 1; end
            4'd9: begin pcw = 1; pcs = 2; end
            4'd10, 4'd11: begin a = 1; b = 3; op = 3; rw = (s == 4'd11); end
            default: ;
        endcase
        return {pcw, pcc, irw, mw, rw, tw, adr, dst, wb, ext, pcs, a, b, op};
    endfunction

    function automatic string req_of(input logic [3:0] s);
        case (s)
            4'd0: return "R2/R11";
            4'd1: return "R3/R11";
            4'd2, 4'd3, 4'd4: return "R4/R11";
            4'd5: return "R5/R11";
            4'd6, 4'd7: return "R6/R11";
            4'd8: return "R7/R11";
            4'd9: return "R9/R11";
            default: return "R8/R11";
        endcase
    endfunction

    function automatic int ref_len(input logic [5:0] op);
        case (op)
            6'h23: return 5;
            6'h2B, 6'h00, 6'h0D: return 4;
            6'h04, 6'h02: return 3;
            default: return 2;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (opcode 0x%0h)", req, act, exp, opcode);
        end
    endtask

    task automatic check_state(input logic [3:0] es, input string req);
        logic [16:0] v;
        v = {pc_wr, pc_wr_cond, ir_wr, mem_wr, reg_wr, tgt_wr, addr_alu, dst_rd,
             wb_mem, ext_sign, pc_src, alu_a, alu_b, alu_op};
        check(state == es, {req, " state"}, int'(state), int'(es));
        check(v == ref_vec(es), {req, " outputs"}, int'(v), int'(ref_vec(es)));
    endtask

    // Runs one instruction from fetch back to fetch and checks its length.
    task automatic run_op(input logic [5:0] op);
        logic [3:0] es;
        int n;
        es = 4'd0;
        n = 0;
        opcode = op;
        do begin
            check_state(es, req_of(es));
            n++;
            es = ref_next(es, op);
            @(negedge clk);
        end while (es != 4'd0 && n < 20);
        check(n == ref_len(op), (ref_len(op) == 2) ? "R10 length" : "R4/R9 length", n, ref_len(op));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_state(4'd0, "R1 reset");
        rst_n = 1'b1;
        for (int op = 0; op < 64; op++) run_op(6'(op));
        // R1: reset in the middle of a register operation
        opcode = 6'h00;
        @(negedge clk);
        @(negedge clk);
        check(state == 4'd6, "R1 pre-reset", int'(state), 6);
        rst_n = 1'b0;
        @(negedge clk);
        check_state(4'd0, "R1 mid reset");
        rst_n = 1'b1;
        run_op(6'h23);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule